// File: doc/BRIEF.md
# Transition Density Activity Detector

This block watches one channel's serial data and decides whether it carries real traffic. Live data is expected to change state on about half of its bit periods. The block counts the level changes between consecutive strobed bits over a fixed measurement interval of `WINDOW` strobes. At the close of each interval it judges whether the count lies inside a fixed tolerance band of three eighths to five eighths of `WINDOW`. When the count leaves that band, the channel is declared idle.

The verdict drives three outputs. The first is an active-high status flag. The second is an active-low pin copy of the same flag, meant for external wiring. The third is a request that keeps the frequency-acquisition loop engaged while activity is missing. When activity returns, the request drops and phase locking can take over again. Each channel gets its own instance. The band limits follow from `WINDOW` alone and cannot be changed at run time. After reset, the channel counts as idle until its first full interval has been judged.

Top module: `act_density_mon`

## Requirements
- R1: While `rst_n` is low, and after its release until the first interval close, `loa` is 1, `loa_n` is 0 and `acq_force` is 1.
- R2: A transition is one strobed bit (`bit_vld` = 1) whose `bit_in` value differs from the previous strobed bit. The first strobed bit after reset counts no transition.
- R3: An interval closes on every `WINDOW`-th strobe. The outputs change only on the clock edge that takes the closing strobe, and they hold their value between closes.
- R4: If the transitions of an interval, including one on the closing strobe, number at least 3·WINDOW/8 and at most 5·WINDOW/8 (96 and 160 for 256), then `loa` becomes 0.
- R5: A count below 3·WINDOW/8 sets `loa` to 1.
- R6: A count above 5·WINDOW/8 sets `loa` to 1.
- R7: `loa_n` is always the inverse of `loa`, and `acq_force` always equals `loa`.
- R8: Changes of `bit_in` in cycles where `bit_vld` is 0 neither count nor alter the remembered previous bit.
- R9: A reset in the middle of an interval discards the partial count and restarts the interval from zero strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | Strobe marking a new sampled data bit |
| bit_in | input | 1 | Sampled data bit |
| loa | output | 1 | Loss-of-activity status, active high |
| loa_n | output | 1 | Loss-of-activity pin, active low |
| acq_force | output | 1 | Request that holds frequency acquisition on |

## Verification
The interval close and the counting of a transition can fall on the same strobe. When they do, the closing bit's transition has to enter the verdict and must not be lost to the counter clear. The bench provokes this case with intervals that hold exactly one transition fewer than a band limit among their first `WINDOW`-1 bits, then toggle on the closing bit. At the lower limit this brings the count to 96 and the channel must read active. Without the closing transition the count would be 95 and the channel would wrongly read idle.

// File: rtl/adm_pkg.sv
package adm_pkg;

   function automatic int band_lo(input int win);
      return (3 * win) / 8;
   endfunction

   function automatic int band_hi(input int win);
      return (5 * win) / 8;
   endfunction

endpackage

// File: rtl/adm_edge_count.sv
module adm_edge_count #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             bit_in,
   input  logic             clr,
   output logic [CNT_W-1:0] total
);

   logic             prev_bit;
   logic             prev_ok;
   logic [CNT_W-1:0] cnt;
   logic             edge_now;

   assign edge_now = bit_vld && prev_ok && (bit_in != prev_bit);
   assign total    = cnt + CNT_W'(edge_now);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         prev_bit <= 1'b0;
         prev_ok  <= 1'b0;
      end else begin
         if (clr)
            cnt <= '0;
         else if (bit_vld)
            cnt <= total;
         if (bit_vld) begin
            prev_bit <= bit_in;
            prev_ok  <= 1'b1;
         end
      end
   end

   // R2: the running count advances by at most one per cycle
   a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));

   // R8: idle cycles change neither the count nor the remembered bit
   a_r8_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_vld && !clr) |=> ($stable(cnt) && $stable(prev_bit)));

endmodule

// File: rtl/adm_window_timer.sv
module adm_window_timer #(
   parameter int WINDOW = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_vld,
   output logic last
);

   localparam int  IDX_W = $clog2(WINDOW);
   localparam bit  POW2  = ((WINDOW & (WINDOW - 1)) == 0);

   logic [IDX_W-1:0] idx;

   assign last = bit_vld && (idx == IDX_W'(WINDOW - 1));

   generate
      if (POW2) begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               idx <= '0;
            else if (bit_vld)
               idx <= idx + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               idx <= '0;
            else if (last)
               idx <= '0;
            else if (bit_vld)
               idx <= idx + 1'b1;
         end
      end
   endgenerate

   // R3: the strobe index never passes the interval length
   a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(idx) < WINDOW);

   // R3: a close starts the next interval from zero strobes
   a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> (idx == '0));

endmodule

// File: rtl/act_density_mon.sv
module act_density_mon #(
   parameter int WINDOW = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_vld,
   input  logic bit_in,
   output logic loa,
   output logic loa_n,
   output logic acq_force
);

   localparam int CNT_W = $clog2(WINDOW + 1);
   localparam int LIM_L = adm_pkg::band_lo(WINDOW);
   localparam int LIM_H = adm_pkg::band_hi(WINDOW);

   generate
      if (WINDOW < 8 || (WINDOW % 8) != 0) begin : g_bad_window
         $error("WINDOW must be a multiple of 8 and at least 8");
      end
   endgenerate

   logic             last;
   logic [CNT_W-1:0] total;
   logic             in_band;
   logic             loa_q;
   logic             seen_q;

   adm_window_timer #(.WINDOW(WINDOW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_vld (bit_vld),
      .last    (last)
   );

   adm_edge_count #(.CNT_W(CNT_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_vld (bit_vld),
      .bit_in  (bit_in),
      .clr     (last),
      .total   (total)
   );

   assign in_band = (total >= CNT_W'(LIM_L)) && (total <= CNT_W'(LIM_H));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loa_q  <= 1'b1;
         seen_q <= 1'b0;
      end else if (last) begin
         loa_q  <= !in_band;
         seen_q <= 1'b1;
      end
   end

   assign loa       = loa_q;
   assign loa_n     = !loa_q;
   assign acq_force = loa_q;

   // R1: idle is reported until the first interval has been judged
   a_r1_idle_until_judged: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |-> loa);

   // R3: no change between closes
   a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !last |=> $stable(loa));

   // R4: in-band count clears the flag
   a_r4_active: assert property (@(posedge clk) disable iff (!rst_n)
      (last && (int'(total) * 8 >= 3 * WINDOW) && (int'(total) * 8 <= 5 * WINDOW))
      |=> !loa);

   // R5: sparse transitions raise the flag
   a_r5_sparse: assert property (@(posedge clk) disable iff (!rst_n)
      (last && (int'(total) * 8 < 3 * WINDOW)) |=> loa);

   // R6: dense transitions raise the flag
   a_r6_dense: assert property (@(posedge clk) disable iff (!rst_n)
      (last && (int'(total) * 8 > 5 * WINDOW)) |=> loa);

endmodule

// File: tb/act_density_mon_test.sv
module act_density_mon_test;

   localparam int W = 256;

   typedef struct packed {
      int n;
      int gap;
      int tail;
      bit exp;
   } vec_t;

   // n toggles, idle cycles per strobe, toggles moved to the end, expected loa
   localparam vec_t VEC [12] = '{
      '{128, 0, 0, 1'b0},   // first after reset: 127 counted, R2/R4
      '{160, 0, 0, 1'b0},   // upper limit R4
      '{161, 0, 0, 1'b1},   // R6
      '{ 96, 1, 0, 1'b0},   // lower limit with idle wiggle R8/R4
      '{ 95, 0, 0, 1'b1},   // R5
      '{  0, 0, 0, 1'b1},   // R5 no edges
      '{256, 0, 0, 1'b1},   // R6 every bit
      '{ 96, 0, 1, 1'b0},   // closing bit toggles R3/R4
      '{160, 0, 1, 1'b0},   // closing bit toggles at upper limit
      '{ 97, 2, 0, 1'b0},   // R8 two idle cycles
      '{ 40, 1, 0, 1'b1},   // R5
      '{128, 0, 0, 1'b0}    // R4
   };

   logic clk = 1'b0;
   logic rst_n;
   logic bit_vld;
   logic bit_in;
   logic loa, loa_n, acq_force;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;
   logic cur   = 1'b0;
   logic prev_exp;

   always #10 clk = ~clk;

   act_density_mon #(.WINDOW(W)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_vld   (bit_vld),
      .bit_in    (bit_in),
      .loa       (loa),
      .loa_n     (loa_n),
      .acq_force (acq_force)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_outs(input string req, input logic exp);
      check(req, loa, exp);
      check({req, "/R7 loa_n"}, loa_n, !exp);
      check({req, "/R7 acq_force"}, acq_force, exp);
   endtask

   task automatic strobe(input bit tog, input int gap);
      @(negedge clk);
      if (tog) cur = ~cur;
      bit_in  = cur;
      bit_vld = 1'b1;
      @(negedge clk);
      bit_vld = 1'b0;
      for (int g = 0; g < gap; g++) begin
         bit_in = ~cur;
         @(negedge clk);
      end
      bit_in = cur;
   endtask

   initial begin
      rst_n   = 1'b0;
      bit_vld = 1'b0;
      bit_in  = 1'b0;
      repeat (3) @(negedge clk);
      check_outs("R1 in reset", 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check_outs("R1 after release", 1'b1);
      prev_exp = 1'b1;

      for (int v = 0; v < 12; v++) begin
         for (int i = 0; i < W; i++) begin
            if (i == W / 2) check("R3 mid-interval hold", loa, prev_exp);
            strobe((i < VEC[v].n - VEC[v].tail) || (i >= W - VEC[v].tail), VEC[v].gap);
         end
         check_outs($sformatf("R4/R5/R6 vector %0d", v), VEC[v].exp);
         prev_exp = VEC[v].exp;
      end

      // R9: reset in the middle of an interval
      for (int i = 0; i < 100; i++) strobe(1'b1, 0);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_outs("R9 reset mid-interval", 1'b1);
      rst_n = 1'b1;
      for (int i = 0; i < W; i++) begin
         if (i == 200) check("R9 interval restarted", loa, 1'b1);
         if (i == W - 1) check("R1 no verdict before close", loa, 1'b1);
         strobe(i < 128, 0);
      end
      check_outs("R4 first verdict after mid reset", 1'b0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule